// File: doc/BRIEF.md
# Alternating Read/Write Start Arbiter

This block is the front end of a split-port memory whose read and write ports share one address bus. On every rising clock edge it looks at two active-low port selects and decides whether a read burst, a write burst or nothing starts in that cycle. It also captures the shared address into a separate register for the port that wins. Each accepted burst occupies its port for two clock cycles, so a port may not start again on the edge straight after its own start. A request made on that edge is dropped.

When both selects are active on the same edge, the winner depends on what was started on the previous edge. After an idle edge the read wins. After a read the write wins. After a write the read wins. If both selects are held active, the starts therefore alternate read, write, read, write, and the sequence always begins with a read. Each start pulse and its captured address appear one cycle after the sampling edge.

Top module: `rw_alt_arbiter`

## Requirements
- R1: After reset, `rd_start` and `wr_start` are 0 and both address outputs are 0. The history is idle, so the first edge with both selects active starts a read.
- R2: A low `rd_sel_n` on an edge that was not preceded by a read start gives `rd_start`=1 in the next cycle, with `rd_addr` equal to the address sampled on that edge.
- R3: A low `wr_sel_n` on an edge that was not preceded by a write start gives `wr_start`=1 in the next cycle, with `wr_addr` equal to the address sampled on that edge.
- R4: A read request on the edge right after a read start is ignored: no `rd_start` follows.
- R5: A write request on the edge right after a write start is ignored: no `wr_start` follows.
- R6: Both selects low, previous edge idle: the read starts.
- R7: Both selects low, previous edge started a read: the write starts.
- R8: Both selects low, previous edge started a write: the read starts.
- R9: Holding both selects low from idle gives starts in the order read, write, read, write, and so on.
- R10: `rd_start` and `wr_start` are never high in the same cycle.
- R11: An address output changes only in a cycle where its own start pulse is high. An ignored or losing request leaves both address outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Positive clock. All sampling happens on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| rd_sel_n | input | 1 | Read port select, active low. |
| wr_sel_n | input | 1 | Write port select, active low. |
| addr | input | ADDR_W | Shared address bus. |
| rd_start | output | 1 | One-cycle pulse: a read burst starts. |
| wr_start | output | 1 | One-cycle pulse: a write burst starts. |
| rd_addr | output | ADDR_W | Address captured for the latest read start. |
| wr_addr | output | ADDR_W | Address captured for the latest write start. |

## Verification
A read request and a write request can land on the same edge. The arbiter then has to grant one, drop the other and keep the loser's address out of both registers. The bench provokes this by holding both selects low after an idle edge, after a read and after a write. It also runs a long stretch with both selects held low. A scoreboard model that knows only the previous grant predicts each outcome, and every cycle it compares both pulses and both address outputs.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;
   typedef enum logic [1:0] {
      GNT_NONE  = 2'd0,
      GNT_READ  = 2'd1,
      GNT_WRITE = 2'd2
   } grant_e;
endpackage

// File: rtl/rw_arb_decide.sv
module rw_arb_decide
   import rw_arb_pkg::*;
(
   input  logic   rd_req,
   input  logic   wr_req,
   input  grant_e last_gnt,
   output grant_e gnt
);
   logic rd_ok;
   logic wr_ok;

   // A port that started on the previous edge is still busy with its burst.
   assign rd_ok = rd_req && (last_gnt != GNT_READ);
   assign wr_ok = wr_req && (last_gnt != GNT_WRITE);

   always_comb begin
      gnt = GNT_NONE;
      if (rd_ok && wr_ok) begin
         // Both were free: the idle history favours the read.
         gnt = GNT_READ;
      end else if (rd_ok) begin
         gnt = GNT_READ;
      end else if (wr_ok) begin
         gnt = GNT_WRITE;
      end
   end
endmodule

// File: rtl/rw_arb_addr_reg.sv
module rw_arb_addr_reg #(
   parameter int unsigned WIDTH     = 17,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (RESET_VAL) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (load) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/rw_alt_arbiter.sv
module rw_alt_arbiter
   import rw_arb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 17,
   parameter bit          ADDR_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_sel_n,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_start,
   output logic              wr_start,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr
);
   localparam int unsigned NPORT = 2;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("rw_alt_arbiter: ADDR_W must be at least 1");
      end
   endgenerate

   grant_e              gnt;
   grant_e              hist_q;
   logic [ADDR_W-1:0]   port_addr [NPORT];

   rw_arb_decide u_decide (
      .rd_req   (!rd_sel_n),
      .wr_req   (!wr_sel_n),
      .last_gnt (hist_q),
      .gnt      (gnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= GNT_NONE;
      else        hist_q <= gnt;
   end

   genvar p;
   generate
      for (p = 0; p < NPORT; p++) begin : g_port
         localparam grant_e OWN = (p == 0) ? GNT_READ : GNT_WRITE;
         rw_arb_addr_reg #(
            .WIDTH     (ADDR_W),
            .RESET_VAL (ADDR_RESET)
         ) u_areg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (gnt == OWN),
            .d     (addr),
            .q     (port_addr[p])
         );
      end
   endgenerate

   assign rd_start = (hist_q == GNT_READ);
   assign wr_start = (hist_q == GNT_WRITE);
   assign rd_addr  = port_addr[0];
   assign wr_addr  = port_addr[1];

   assert_one_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_start && wr_start));
   assert_no_back_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);
   assert_no_back_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);
   assert_idle_both_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_start && !wr_start && !rd_sel_n) |=> rd_start);
   assert_after_read_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !wr_sel_n) |=> wr_start);
   assert_after_write_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !rd_sel_n) |=> rd_start);
   assert_rd_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |-> $stable(rd_addr));
   assert_wr_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_start |-> $stable(wr_addr));
endmodule

// File: tb/tb_rw_alt_arbiter.sv
module tb_rw_alt_arbiter;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          rd_start, wr_start;
   logic [AW-1:0] rd_addr, wr_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // expected item: {rd_start, wr_start, rd_addr, wr_addr}
   logic [2*AW+1:0] q_exp [$];
   string           q_tag [$];

   // model state: 0 idle, 1 read, 2 write
   int            m_hist = 0;
   logic [AW-1:0] m_raddr = '0;
   logic [AW-1:0] m_waddr = '0;

   rw_alt_arbiter #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr(addr), .rd_start(rd_start), .wr_start(wr_start),
      .rd_addr(rd_addr), .wr_addr(wr_addr)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [2*AW+1:0] act,
                        input logic [2*AW+1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a,
                       input string tag);
      int g;
      @(negedge clk);
      rd_sel_n = rn;
      wr_sel_n = wn;
      addr     = a;
      if (!rn && !wn) begin
         case (m_hist)
            0:       g = 1;
            1:       g = 2;
            default: g = 1;
         endcase
      end else if (!rn) begin
         g = (m_hist == 1) ? 0 : 1;
      end else if (!wn) begin
         g = (m_hist == 2) ? 0 : 2;
      end else begin
         g = 0;
      end
      if (g == 1) m_raddr = a;
      if (g == 2) m_waddr = a;
      m_hist = g;
      q_exp.push_back({(g == 1), (g == 2), m_raddr, m_waddr});
      q_tag.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (q_exp.size() > 0) begin
         check(q_tag.pop_front(), {rd_start, wr_start, rd_addr, wr_addr},
               q_exp.pop_front());
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", {rd_start, wr_start, rd_addr, wr_addr}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 17'h00111, "R1 R6 first both after reset");
      step(1'b1, 1'b1, 17'h1ffff, "idle");
      step(1'b0, 1'b1, 17'h0a5a5, "R2 read alone");
      step(1'b0, 1'b1, 17'h05a5a, "R4 R11 back-to-back read dropped");
      step(1'b1, 1'b1, 17'h00000, "idle");
      step(1'b1, 1'b0, 17'h13579, "R3 write alone");
      step(1'b1, 1'b0, 17'h02468, "R5 R11 back-to-back write dropped");
      step(1'b1, 1'b1, 17'h00001, "idle");
      step(1'b0, 1'b0, 17'h10001, "R6 both from idle");
      step(1'b0, 1'b0, 17'h10002, "R7 both after read");
      step(1'b0, 1'b0, 17'h10003, "R8 both after write");
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 1'b0, AW'(17'h08000 + i), "R9 R10 held both");
      end
      step(1'b1, 1'b1, 17'h00000, "idle");
      step(1'b1, 1'b0, 17'h0beef, "R3 write after idle");
      step(1'b0, 1'b1, 17'h0cafe, "R2 read after write");
      step(1'b1, 1'b0, 17'h0dead, "R3 write after read");
      step(1'b0, 1'b0, 17'h00abc, "R8 R11 both after write");
      step(1'b1, 1'b1, 17'h00000, "idle");
      step(1'b1, 1'b1, 17'h00000, "idle");
      repeat (2) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule